// File: doc/BRIEF.md
# Serial EEPROM Status Register and Write-Permission Control

This block holds the status register of a small serial EEPROM and decides whether each write-type instruction may start. The instruction decoder in front of it turns each received opcode into a one-cycle strobe: enable writes, disable writes, write the status register, or write the array. The block also watches the write-protect pin, a power-on reset and a supply-drop event. It answers with a live status byte, a grant pulse for each accepted write, and a flag that tells whether the address on `wrAddr` lies in the protected region.

The register has three parts. The write-enable latch (WEL) can be set only by the enable instruction and is cleared by several events. The two block-protect bits select how much of the array is write-protected. They keep their value across power-on reset, so they behave like non-volatile storage. The busy bit (WIP) is high for the length of a modelled internal write cycle. A counter of `WR_CYCLES` clocks stands in for the analog write timer. While the cycle runs, every instruction is ignored. The status byte stays readable and shows the live busy bit.

A status read needs no strobe, because `statusByte` is always valid. The serial shifter presents it whenever a read-status opcode arrives.

Top module: `eeprom_status_ctrl`

## Requirements
- R1: `statusByte` reads {4'b1111, BP1, BP0, WEL, WIP}: bits 7..4 are always 1, bit 3 is BP1, bit 2 is BP0, bit 1 is WEL and bit 0 is WIP.
- R2: WEL goes to 1 on the clock edge after a `cmdWren` cycle in which WIP is 0, unless a clearing event happens in the same cycle. No other input sets WEL.
- R3: A `cmdWrdi` cycle with WIP at 0 clears WEL at the next edge.
- R4: When WEL is 0, `cmdWrite` and `cmdWrsr` raise no grant and WIP stays 0.
- R5: `wrGrant` is high in the same cycle as `cmdWrite` exactly when WEL is 1, WIP is 0 and `protFlag` is 0. `srGrant` is high in the same cycle as `cmdWrsr` exactly when WEL is 1 and WIP is 0. After either grant, WIP reads 1 from the next edge.
- R6: `protFlag` is a function of the protect bits and `wrAddr` for depth 2^AW. Code 00 protects nothing. Code 01 protects addresses at or above 3/4 of the depth. Code 10 protects addresses at or above 1/2 of the depth. Code 11 protects every address.
- R7: A granted `cmdWrsr` loads `newBp` (bits 3:2 of the written byte) into BP1:BP0 only if `wpN` is 1 in that cycle. While `wpN` is 0, the protect bits do not change.
- R8: WIP stays 1 for exactly `WR_CYCLES` cycles. `wrDone` is high in the last of them, and at the next edge both WIP and WEL read 0.
- R9: While WIP is 1, `cmdWren`, `cmdWrdi`, `cmdWrite` and `cmdWrsr` have no effect and raise no grant.
- R10: A 1-to-0 transition of `wpN` clears WEL at the next edge. It takes priority over a `cmdWren` in the same cycle.
- R11: `supplyDrop` high clears WEL at the next edge, with priority over `cmdWren`.
- R12: `porN` low clears WEL and WIP at once. BP1:BP0 keep their value across the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| supplyDrop | input | 1 | Supply-drop event, clears WEL |
| wpN | input | 1 | Write-protect pin level, low = hardware protect |
| cmdWren | input | 1 | Write-enable instruction strobe |
| cmdWrdi | input | 1 | Write-disable instruction strobe |
| cmdWrsr | input | 1 | Status-write instruction strobe |
| cmdWrite | input | 1 | Array-write instruction strobe |
| newBp | input | 2 | Protect code carried by a status write |
| wrAddr | input | AW | Target address of an array write |
| statusByte | output | 8 | Live status register |
| wrGrant | output | 1 | Array write accepted this cycle |
| srGrant | output | 1 | Status write accepted this cycle |
| protFlag | output | 1 | `wrAddr` lies in the protected region |
| wrDone | output | 1 | Last cycle of the internal write |

## Verification
The assertions assume that the decoder raises at most one instruction strobe per cycle, and that all inputs change only away from the rising edge. The random stimulus picks a single instruction, or none, in each cycle. Against that background it toggles `wpN` now and then, and it injects rare supply-drop and reset pulses at low rates, so that each clearing event can overlap enable instructions and running write cycles.

// File: rtl/eeprom_stat_pkg.sv
package eeprom_stat_pkg;
  // Strobes passed from the control to the register datapath
  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic loadBp;
    logic startWr;
    logic endWr;
  } statStrobeT;
endpackage

// File: rtl/eeprom_stat_dp.sv
module eeprom_stat_dp
  import eeprom_stat_pkg::*;
#(
  parameter int AW = 7,
  parameter logic [1:0] BP_INIT = 2'b00
) (
  input  logic          clk,
  input  logic          porN,
  input  statStrobeT    strb,
  input  logic [1:0]    newBp,
  input  logic [AW-1:0] wrAddr,
  output logic          wel,
  output logic          wip,
  output logic [7:0]    statusByte,
  output logic          protFlag
);
  localparam int DEPTH = 1 << AW;
  localparam int HALF_BASE = DEPTH / 2;
  localparam int QTR_BASE = DEPTH - DEPTH / 4;

  // Protect bits are not touched by reset: they stand for non-volatile cells
  logic [1:0] bpQ = BP_INIT;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)              wel <= 1'b0;
    else if (strb.clrWel)   wel <= 1'b0;
    else if (strb.setWel)   wel <= 1'b1;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)              wip <= 1'b0;
    else if (strb.endWr)    wip <= 1'b0;
    else if (strb.startWr)  wip <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strb.loadBp) bpQ <= newBp;
  end

  logic [AW:0] addrExt;
  assign addrExt = {1'b0, wrAddr};

  always_comb begin
    unique case (bpQ)
      2'b00:   protFlag = 1'b0;
      2'b01:   protFlag = addrExt >= (AW+1)'(QTR_BASE);
      2'b10:   protFlag = addrExt >= (AW+1)'(HALF_BASE);
      default: protFlag = 1'b1;
    endcase
  end

  assign statusByte = {4'hF, bpQ, wel, wip};
endmodule

// File: rtl/eeprom_stat_ctl.sv
module eeprom_stat_ctl
  import eeprom_stat_pkg::*;
#(
  parameter int WR_CYCLES = 8
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       supplyDrop,
  input  logic       wpN,
  input  logic       cmdWren,
  input  logic       cmdWrdi,
  input  logic       cmdWrsr,
  input  logic       cmdWrite,
  input  logic       wel,
  input  logic       wip,
  input  logic       protFlag,
  output statStrobeT strb,
  output logic       wrGrant,
  output logic       srGrant,
  output logic       wrDone
);
  localparam int CW = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WR_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic wpQ;
  logic wpFall;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) wpQ <= 1'b0;
    else       wpQ <= wpN;
  end
  assign wpFall = wpQ & ~wpN;

  assign wrGrant = cmdWrite & wel & ~wip & ~protFlag;
  assign srGrant = cmdWrsr & wel & ~wip;
  assign wrDone  = wip & (cnt == '0);

  always_comb begin
    strb.startWr = wrGrant | srGrant;
    strb.endWr   = wrDone;
    strb.loadBp  = srGrant & wpN;
    strb.setWel  = cmdWren & ~wip;
    strb.clrWel  = (cmdWrdi & ~wip) | wpFall | supplyDrop | wrDone;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                    cnt <= '0;
    else if (strb.startWr)        cnt <= LAST;
    else if (wip && cnt != '0)    cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/eeprom_status_ctrl.sv
module eeprom_status_ctrl
  import eeprom_stat_pkg::*;
#(
  parameter int AW = 7,
  parameter int WR_CYCLES = 8,
  parameter logic [1:0] BP_INIT = 2'b00
) (
  input  logic          clk,
  input  logic          porN,
  input  logic          supplyDrop,
  input  logic          wpN,
  input  logic          cmdWren,
  input  logic          cmdWrdi,
  input  logic          cmdWrsr,
  input  logic          cmdWrite,
  input  logic [1:0]    newBp,
  input  logic [AW-1:0] wrAddr,
  output logic [7:0]    statusByte,
  output logic          wrGrant,
  output logic          srGrant,
  output logic          protFlag,
  output logic          wrDone
);
  statStrobeT strb;
  logic wel;
  logic wip;

  eeprom_stat_ctl #(.WR_CYCLES(WR_CYCLES)) u_ctl (
    .clk(clk), .porN(porN), .supplyDrop(supplyDrop), .wpN(wpN),
    .cmdWren(cmdWren), .cmdWrdi(cmdWrdi), .cmdWrsr(cmdWrsr), .cmdWrite(cmdWrite),
    .wel(wel), .wip(wip), .protFlag(protFlag),
    .strb(strb), .wrGrant(wrGrant), .srGrant(srGrant), .wrDone(wrDone)
  );

  eeprom_stat_dp #(.AW(AW), .BP_INIT(BP_INIT)) u_dp (
    .clk(clk), .porN(porN), .strb(strb), .newBp(newBp), .wrAddr(wrAddr),
    .wel(wel), .wip(wip), .statusByte(statusByte), .protFlag(protFlag)
  );
endmodule

// File: rtl/eeprom_status_chk.sv
module eeprom_status_chk (
  input logic       clk,
  input logic       porN,
  input logic       wpN,
  input logic       cmdWren,
  input logic [7:0] statusByte,
  input logic       wrGrant,
  input logic       srGrant,
  input logic       protFlag,
  input logic       wrDone
);
  a_r1_fixed_ones: assert property (@(posedge clk) disable iff (!porN)
    statusByte[7:4] == 4'hF);

  a_r2_wel_only_by_wren: assert property (@(posedge clk) disable iff (!porN)
    $rose(statusByte[1]) |-> $past(cmdWren));

  a_r4_grant_needs_wel: assert property (@(posedge clk) disable iff (!porN)
    (wrGrant || srGrant) |-> statusByte[1]);

  a_r5_grant_starts_busy: assert property (@(posedge clk) disable iff (!porN)
    (wrGrant || srGrant) |=> statusByte[0]);

  a_r6_no_grant_protected: assert property (@(posedge clk) disable iff (!porN)
    wrGrant |-> !protFlag);

  a_r7_bp_frozen_when_wp_low: assert property (@(posedge clk) disable iff (!porN)
    !wpN |=> $stable(statusByte[3:2]));

  a_r8_done_clears_wel_wip: assert property (@(posedge clk) disable iff (!porN)
    wrDone |=> (statusByte[1:0] == 2'b00));

  a_r9_no_grant_while_busy: assert property (@(posedge clk) disable iff (!porN)
    statusByte[0] |-> !(wrGrant || srGrant));
endmodule

bind eeprom_status_ctrl eeprom_status_chk u_chk (
  .clk(clk), .porN(porN), .wpN(wpN), .cmdWren(cmdWren),
  .statusByte(statusByte), .wrGrant(wrGrant), .srGrant(srGrant),
  .protFlag(protFlag), .wrDone(wrDone)
);

// File: tb/eeprom_status_ctrl_test.sv
`timescale 1ns/1ps
module eeprom_status_ctrl_test;
  localparam int AW = 7;
  localparam int WRC = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic porN = 1'b0, supplyDrop = 1'b0, wpN = 1'b1;
  logic cmdWren = 1'b0, cmdWrdi = 1'b0, cmdWrsr = 1'b0, cmdWrite = 1'b0;
  logic [1:0] newBp = 2'b00;
  logic [AW-1:0] wrAddr = '0;
  logic [7:0] statusByte;
  logic wrGrant, srGrant, protFlag, wrDone;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  // reference state
  logic mWel = 1'b0, mWip = 1'b0, mWpQ = 1'b0;
  logic [1:0] mBp = 2'b00;
  int mCnt = 0;

  always #4 clk = ~clk;

  eeprom_status_ctrl #(.AW(AW), .WR_CYCLES(WRC)) uut (
    .clk(clk), .porN(porN), .supplyDrop(supplyDrop), .wpN(wpN),
    .cmdWren(cmdWren), .cmdWrdi(cmdWrdi), .cmdWrsr(cmdWrsr), .cmdWrite(cmdWrite),
    .newBp(newBp), .wrAddr(wrAddr), .statusByte(statusByte),
    .wrGrant(wrGrant), .srGrant(srGrant), .protFlag(protFlag), .wrDone(wrDone)
  );

  function automatic logic expProt(logic [1:0] bp, int addr);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return addr >= (DEPTH * 3) / 4;
      2'b10:   return addr >= DEPTH / 2;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare, then advance the model at posedge
  task automatic step(string tag, logic ren, logic rdi, logic rsr, logic rwr,
                      logic [1:0] bp, int addr, logic wp, logic drop, logic por);
    logic pr, wg, sg, dn, busy, fall;
    @(negedge clk);
    cmdWren = ren; cmdWrdi = rdi; cmdWrsr = rsr; cmdWrite = rwr;
    newBp = bp; wrAddr = AW'(addr); wpN = wp; supplyDrop = drop; porN = por;
    #1;
    if (!por) begin mWel = 1'b0; mWip = 1'b0; mCnt = 0; mWpQ = 1'b0; end
    busy = mWip;
    pr = expProt(mBp, addr);
    wg = rwr && mWel && !busy && !pr;
    sg = rsr && mWel && !busy;
    dn = busy && (mCnt == 0);
    check(tag, "statusByte", int'(statusByte), int'({4'hF, mBp, mWel, mWip}));
    check(tag, "wrGrant", int'(wrGrant), int'(wg));
    check(tag, "srGrant", int'(srGrant), int'(sg));
    check(tag, "protFlag", int'(protFlag), int'(pr));
    check(tag, "wrDone", int'(wrDone), int'(dn));
    @(posedge clk);
    if (por) begin
      fall = mWpQ && !wp;
      if (busy) begin
        if (mCnt == 0) mWip = 1'b0; else mCnt--;
      end else if (wg || sg) begin
        mWip = 1'b1; mCnt = WRC - 1;
        if (sg && wp) mBp = bp;
      end
      if ((rdi && !busy) || fall || drop || dn) mWel = 1'b0;
      else if (ren && !busy) mWel = 1'b1;
      mWpQ = wp;
    end
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 2'b00, 0, 1, 0, 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // reset state (R12, R1)
    step("R12", 0, 0, 0, 0, 2'b00, 0, 1, 0, 0);
    step("R12", 0, 0, 0, 0, 2'b00, 0, 1, 0, 0);
    idle("R1", 2);
    // writes without WEL are ignored (R4)
    step("R4", 0, 0, 0, 1, 2'b00, 5, 1, 0, 1);
    step("R4", 0, 0, 1, 0, 2'b11, 0, 1, 0, 1);
    idle("R4", 1);
    // set then clear WEL (R2, R3)
    step("R2", 1, 0, 0, 0, 2'b00, 0, 1, 0, 1);
    step("R3", 0, 1, 0, 0, 2'b00, 0, 1, 0, 1);
    idle("R3", 1);
    // array write and full write cycle (R5, R8), busy ignores all (R9)
    step("R2", 1, 0, 0, 0, 2'b00, 0, 1, 0, 1);
    step("R5", 0, 0, 0, 1, 2'b00, 127, 1, 0, 1);
    step("R9", 0, 1, 0, 0, 2'b00, 0, 1, 0, 1);
    step("R9", 0, 0, 0, 1, 2'b00, 3, 1, 0, 1);
    step("R9", 1, 0, 0, 0, 2'b00, 0, 1, 0, 1);
    idle("R8", WRC + 2);
    // status write loads protect bits with pin high (R7), then R6 boundaries
    step("R2", 1, 0, 0, 0, 2'b00, 0, 1, 0, 1);
    step("R7", 0, 0, 1, 0, 2'b01, 0, 1, 0, 1);
    idle("R8", WRC + 1);
    step("R6", 0, 0, 0, 0, 2'b00, 95, 1, 0, 1);
    step("R6", 0, 0, 0, 0, 2'b00, 96, 1, 0, 1);
    step("R2", 1, 0, 0, 0, 2'b00, 0, 1, 0, 1);
    step("R6", 0, 0, 0, 1, 2'b00, 96, 1, 0, 1);
    step("R2", 1, 0, 0, 0, 2'b00, 0, 1, 0, 1);
    step("R7", 0, 0, 1, 0, 2'b11, 0, 1, 0, 1);
    idle("R8", WRC + 1);
    step("R6", 0, 0, 0, 0, 2'b00, 0, 1, 0, 1);
    // pin fall clears WEL, beating WREN (R10)
    step("R2", 1, 0, 0, 0, 2'b00, 0, 1, 0, 1);
    step("R10", 1, 0, 0, 0, 2'b00, 0, 0, 0, 1);
    step("R10", 0, 0, 0, 0, 2'b00, 0, 0, 0, 1);
    // protect bits frozen under hardware protect (R7)
    step("R2", 1, 0, 0, 0, 2'b00, 0, 0, 0, 1);
    step("R7", 0, 0, 1, 0, 2'b00, 0, 0, 0, 1);
    idle("R7", WRC + 1);
    // supply drop beats WREN (R11)
    step("R11", 1, 0, 0, 0, 2'b00, 0, 1, 1, 1);
    step("R2", 1, 0, 0, 0, 2'b00, 0, 1, 0, 1);
    step("R11", 0, 0, 0, 0, 2'b00, 0, 1, 1, 1);
    idle("R11", 1);
    // reset mid-write keeps protect bits (R12)
    step("R2", 1, 0, 0, 0, 2'b00, 0, 1, 0, 1);
    step("R5", 0, 0, 1, 0, 2'b10, 0, 1, 0, 1);
    step("R12", 0, 0, 0, 0, 2'b00, 0, 1, 0, 0);
    idle("R12", 2);
    // random mix
    for (int i = 0; i < 6000; i++) begin
      int r;
      logic ren, rdi, rsr, rwr, wp, drop, por;
      r = int'($urandom % 16);
      ren = (r < 5); rdi = (r == 5); rsr = (r == 6 || r == 7); rwr = (r >= 8 && r < 12);
      wp = ($urandom % 20) != 0;
      drop = ($urandom % 64) == 0;
      por = ($urandom % 300) != 0;
      step("R9", ren, rdi, rsr, rwr, 2'($urandom), int'($urandom % DEPTH), wp, drop, por);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule